// File: doc/BRIEF.md
# Unsigned Min/Max Sorter

The sorter takes two unsigned operands of a parameterised width and returns them in ascending order: the smaller value on one output, the larger on the other. A magnitude comparator scans the operands from the most significant bit down and raises exactly one of three flags: less-than, equal or greater-than. The greater-than flag steers a two-lane swap crossbar built from two shared-select multiplexers. When it is clear the operands pass straight through. When it is set they are exchanged.

The three comparison flags leave the block next to the ordered pair, so a consumer that needs the relation does not have to compare the operands a second time. A parameter places an optional output register after the crossbar. With the register (the default), every output is available one clock edge after its operands are presented. Without it the block is purely combinational.

Top module: `minmax_sorter`

## Requirements
- R1: `x_o` equals the unsigned minimum of `a_i` and `b_i`, and `y_o` equals the unsigned maximum.
- R2: Exactly one of `lt_o`, `eq_o` and `gt_o` is 1. `lt_o` means a<b, `eq_o` means a==b and `gt_o` means a>b, all compared as unsigned values.
- R3: When a>b, the crossbar swaps the operands: `x_o` = `b_i` and `y_o` = `a_i`.
- R4: When a<=b, the operands pass straight through: `x_o` = `a_i` and `y_o` = `b_i`. Equal operands are not swapped.
- R5: With `REG_OUT`=1, every output reflects the operands sampled at the previous rising edge of `clk_i`. With `REG_OUT`=0, the outputs follow the current operands without a register.
- R6: While `rst_ni` is low, the registered outputs `x_o`, `y_o`, `lt_o`, `eq_o` and `gt_o` are all 0, whatever the operands are.
- R7: `x_o` <= `y_o` always holds, and {`x_o`,`y_o`} is a permutation of the operands. This holds for every width `W`, whose default is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| x_o | output | W | Smaller operand |
| y_o | output | W | Larger operand |
| lt_o | output | 1 | a_i less than b_i |
| eq_o | output | 1 | a_i equal to b_i |
| gt_o | output | 1 | a_i greater than b_i; this is also the swap select |

## Verification
In the registered variant, all five results for an operand pair are due at the first rising edge after that pair is driven. The combinational variant shows them as soon as the pair settles. The driver applies each pair on a falling edge and queues the expected item. The monitor pops one item per cycle, one time unit after the next rising edge. At that point both the registered and the combinational instance show the pair driven half a cycle before, so one sampling point is correct for both latencies. Reset values are sampled away from any edge while reset is held.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmp_flags_t;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/minmax_cmp.sv
module minmax_cmp
  import minmax_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_flags_t   flags_o
);
  // MSB-first scan: the first differing bit decides the relation
  logic decided;
  logic a_big;

  always_comb begin
    decided = 1'b0;
    a_big   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && (a_i[i] != b_i[i])) begin
        decided = 1'b1;
        a_big   = a_i[i];
      end
    end
  end

  assign flags_o.lt = decided & ~a_big;
  assign flags_o.gt = decided & a_big;
  assign flags_o.eq = ~decided;
endmodule

// File: rtl/minmax_xbar.sv
module minmax_xbar
  import minmax_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         swap_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic [NUM_LANES-1:0][W-1:0] straight;
  logic [NUM_LANES-1:0][W-1:0] crossed;
  logic [NUM_LANES-1:0][W-1:0] lane_out;

  assign straight[0] = a_i;
  assign straight[1] = b_i;
  assign crossed[0]  = b_i;
  assign crossed[1]  = a_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_out[l] = swap_i ? crossed[l] : straight[l];
  end

  assign x_o = lane_out[0];
  assign y_o = lane_out[1];
endmodule

// File: rtl/minmax_sorter.sv
module minmax_sorter
  import minmax_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o
);
  cmp_flags_t   flags;
  logic [W-1:0] x_d, y_d;

  minmax_cmp #(.W(W)) u_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .flags_o(flags)
  );

  minmax_xbar #(.W(W)) u_xbar (
    .a_i   (a_i),
    .b_i   (b_i),
    .swap_i(flags.gt),
    .x_o   (x_d),
    .y_o   (y_d)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] x_q, y_q;
    cmp_flags_t   flags_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q     <= '0;
        y_q     <= '0;
        flags_q <= '0;
      end else begin
        x_q     <= x_d;
        y_q     <= y_d;
        flags_q <= flags;
      end
    end

    assign x_o  = x_q;
    assign y_o  = y_q;
    assign lt_o = flags_q.lt;
    assign eq_o = flags_q.eq;
    assign gt_o = flags_q.gt;

    // R2: exactly one flag once a full cycle out of reset
    p_one_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ($countones({lt_o, eq_o, gt_o}) == 1));
    // R7: ordered outputs
    p_ordered_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (x_o <= y_o));
    // R3: swap of previous operands when a>b
    p_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i > b_i) |=> (x_o == $past(b_i) && y_o == $past(a_i) && gt_o));
    // R4: pass-through including equal operands
    p_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i <= b_i) |=> (x_o == $past(a_i) && y_o == $past(b_i) && !gt_o));
    // R6: reset clears outputs
    p_reset_clear_r6: assert property (@(posedge clk_i)
      !rst_ni |-> (x_o == '0 && y_o == '0 && !lt_o && !eq_o && !gt_o));
  end else begin : g_comb
    assign x_o  = x_d;
    assign y_o  = y_d;
    assign lt_o = flags.lt;
    assign eq_o = flags.eq;
    assign gt_o = flags.gt;

    p_one_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({lt_o, eq_o, gt_o}) == 1);
    p_ordered_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      x_o <= y_o);
    p_perm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (x_o == a_i && y_o == b_i) || (x_o == b_i && y_o == a_i));
    p_min_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lt_o |-> (x_o == a_i));
  end
endmodule

// File: tb/minmax_sorter_tb.sv
module minmax_sorter_tb;
  localparam int WIDE   = 8;
  localparam int NARROW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [WIDE-1:0]   a_w, b_w, x_w, y_w;
  logic              lt_w, eq_w, gt_w;
  logic [NARROW-1:0] a_n, b_n, x_n, y_n;
  logic              lt_n, eq_n, gt_n;

  minmax_sorter #(.W(WIDE), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_w), .b_i(b_w),
    .x_o(x_w), .y_o(y_w), .lt_o(lt_w), .eq_o(eq_w), .gt_o(gt_w)
  );

  minmax_sorter #(.W(NARROW), .REG_OUT(1'b0)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_n), .b_i(b_n),
    .x_o(x_n), .y_o(y_n), .lt_o(lt_n), .eq_o(eq_n), .gt_o(gt_n)
  );

  typedef struct {
    logic [WIDE-1:0] a;
    logic [WIDE-1:0] b;
  } item_t;

  item_t q_w[$];
  item_t q_n[$];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic score(input string tag, input item_t it,
                       input logic [WIDE-1:0] x, input logic [WIDE-1:0] y,
                       input logic lt, input logic eq, input logic gt);
    logic [WIDE-1:0] mn, mx;
    mn = (it.a < it.b) ? it.a : it.b;
    mx = (it.a < it.b) ? it.b : it.a;
    chk(x == mn, "R1", {tag, " min"}, x, mn);
    chk(y == mx, "R1", {tag, " max"}, y, mx);
    chk({lt, eq, gt} == {it.a < it.b, it.a == it.b, it.a > it.b}, "R2",
        {tag, " flags"}, {lt, eq, gt}, {it.a < it.b, it.a == it.b, it.a > it.b});
    if (it.a > it.b)
      chk(x == it.b && y == it.a, "R3", {tag, " swap"}, {x, y}, {it.b, it.a});
    else
      chk(x == it.a && y == it.b, "R4", {tag, " pass"}, {x, y}, {it.a, it.b});
    chk(x <= y, "R7", {tag, " order"}, {x, y}, {mn, mx});
  endtask

  // Monitor: result due one edge after the falling-edge drive (R5)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_w.size() > 0) score("wide", q_w.pop_front(), x_w, y_w, lt_w, eq_w, gt_w);
      if (q_n.size() > 0) score("narrow", q_n.pop_front(), {4'b0, x_n}, {4'b0, y_n},
                                lt_n, eq_n, gt_n);
    end
  end

  task automatic drive(input logic [WIDE-1:0] aw, input logic [WIDE-1:0] bw,
                       input logic [NARROW-1:0] an, input logic [NARROW-1:0] bn);
    @(negedge clk);
    a_w = aw; b_w = bw; a_n = an; b_n = bn;
    q_w.push_back('{aw, bw});
    q_n.push_back('{{4'b0, an}, {4'b0, bn}});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_w = 8'hC3; b_w = 8'h11; a_n = 4'h9; b_n = 4'h2;
    repeat (3) @(negedge clk);
    #1;
    // R6: registered outputs held at zero during reset
    chk(x_w == 0 && y_w == 0, "R6", "reset data", {x_w, y_w}, 0);
    chk({lt_w, eq_w, gt_w} == 3'b000, "R6", "reset flags", {lt_w, eq_w, gt_w}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive narrow sweep, random wide pairs alongside
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        drive(WIDE'($urandom), WIDE'($urandom), NARROW'(i), NARROW'(j));

    // Wide boundary pairs
    drive(8'h00, 8'h00, 4'h0, 4'h0);
    drive(8'hFF, 8'hFF, 4'hF, 4'hF);
    drive(8'h00, 8'hFF, 4'h0, 4'hF);
    drive(8'hFF, 8'h00, 4'hF, 4'h0);
    drive(8'h80, 8'h7F, 4'h8, 4'h7);
    drive(8'h7F, 8'h80, 4'h7, 4'h8);
    drive(8'h5A, 8'h5B, 4'h5, 4'h5);

    for (int k = 0; k < 600; k++)
      drive(WIDE'($urandom), WIDE'($urandom), NARROW'($urandom), NARROW'($urandom));

    repeat (4) @(negedge clk);
    chk(q_w.size() == 0 && q_n.size() == 0, "R5", "queues drained",
        q_w.size() + q_n.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule